// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block makes a pulse-width-modulated output from an 8-bit period timer. A fine counter runs on every enabled clock and divides the input clock by 4, 16 or 64. Each time it wraps, the timer steps by one. The division is 4 times a prescale ratio of 1, 4 or 16. The two upper bits of the fine counter's active range extend the timer to a 10-bit position inside the period. The timer restarts after it reaches the programmed period value. One full period therefore spans (period+1)×4×prescale input clocks.

Software writes a 10-bit duty value through a small write-only register port, in two pieces. The pieces sit in a staging buffer. The buffer is copied into a shadow compare register only at the period boundary, so a write during a pulse never cuts that pulse short or stretches it. The output goes high as each period starts, unless the shadow duty is zero. It drops when the 10-bit position reaches the shadow duty. The shadow duty and the timer value are visible as outputs. A control bit enables the generator. While it is clear, the counters freeze and the output is low.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset, pwm_out is 0, timer_count is 0 and shadow_duty is 0. The period register holds 0xFF, the prescale ratio is 1 and the generator is disabled.
- R2: A write with reg_wr high stores reg_wdata according to reg_addr. Address 0 holds duty bits 9:2. Address 1 holds duty bits 1:0, taken from reg_wdata[1:0]. Address 2 holds the period. Address 3 is control: bit 2 is the enable, and bits 1:0 select the prescale (00 for 1, 01 for 4, 1x for 16).
- R3: While enabled, successive rising edges of pwm_out are (period+1)×4×prescale clocks apart.
- R4: For a shadow duty D with 0 < D < 4×(period+1), pwm_out stays high for exactly D×prescale clocks in each period.
- R5: For a shadow duty D of at least 4×(period+1), pwm_out stays high for the whole period and through the boundary.
- R6: A shadow duty of 0 keeps pwm_out low for the whole period.
- R7: A duty write has no effect on the current period. shadow_duty takes the staged value only at the period boundary, and the pulse after that boundary uses it.
- R8: Clearing the enable drives pwm_out low from the next clock. timer_count then holds its value while disabled.
- R9: pwm_out rises only on the clock that starts a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| pwm_out | output | 1 | Registered PWM output |
| shadow_duty | output | 10 | Duty value in use for the current period |
| timer_count | output | 8 | Current timer value |

## Verification
The assertions assume that the prescale select and the period are changed only while the generator is disabled or right after reset. Under that assumption the fine counter never sits above its wrap limit, and the timer never passes the period and runs on to overflow. The stimulus keeps to this. Each scenario resets the block, programs the period, duty and prescale, and only then sets the enable. The one exception is the duty registers, which are written in the middle of a pulse on purpose. The random cases keep the period small and the duty below the full-period value, so that every pulse has a measurable falling edge.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // log2 of the largest prescale ratio (16)
  localparam int unsigned PS_LOG_MAX = 4;

  typedef enum logic [1:0] {
    ADDR_DUTY_HI = 2'd0,
    ADDR_DUTY_LO = 2'd1,
    ADDR_PERIOD  = 2'd2,
    ADDR_CTRL    = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int unsigned CTRL_EN_BIT = 2;

  // prescale select to right-shift amount (log2 of ratio)
  function automatic logic [2:0] ps_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   ps_shift = 3'd0;
      2'b01:   ps_shift = 3'd2;
      default: ps_shift = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic [1:0]                addr_i,
  input  logic [TMR_W-1:0]          wdata_i,
  output logic [TMR_W+FRAC_W-1:0]   dbuf_o,
  output logic [TMR_W-1:0]          period_o,
  output logic                      en_o,
  output logic [1:0]                ps_sel_o
);

  logic [TMR_W-1:0]  duty_hi_q;
  logic [FRAC_W-1:0] duty_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      period_o  <= '1;
      en_o      <= 1'b0;
      ps_sel_o  <= 2'b00;
    end else if (wr_i) begin
      case (reg_addr_e'(addr_i))
        ADDR_DUTY_HI: duty_hi_q <= wdata_i;
        ADDR_DUTY_LO: duty_lo_q <= wdata_i[FRAC_W-1:0];
        ADDR_PERIOD:  period_o  <= wdata_i;
        ADDR_CTRL: begin
          en_o     <= wdata_i[CTRL_EN_BIT];
          ps_sel_o <= wdata_i[1:0];
        end
        default: ;
      endcase
    end
  end

  assign dbuf_o = {duty_hi_q, duty_lo_q};

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic [1:0]                ps_sel_i,
  input  logic [TMR_W-1:0]          period_i,
  output logic [TMR_W-1:0]          tmr_o,
  output logic                      period_end_o,
  output logic [TMR_W+FRAC_W-1:0]   ext_next_o
);

  localparam int unsigned CNT_W = FRAC_W + PS_LOG_MAX;

  logic [2:0]       shift;
  logic [CNT_W-1:0] lim, fcnt_q, fcnt_n, fsh;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             tick_last, at_top;

  always_comb begin
    shift     = ps_shift(ps_sel_i);
    lim       = {CNT_W{1'b1}} >> (3'(PS_LOG_MAX) - shift);
    tick_last = (fcnt_q >= lim);
    at_top    = (tmr_q == period_i);
    fcnt_n    = fcnt_q;
    tmr_n     = tmr_q;
    if (en_i) begin
      if (tick_last) begin
        fcnt_n = '0;
        tmr_n  = at_top ? '0 : tmr_q + 1'b1;
      end else begin
        fcnt_n = fcnt_q + 1'b1;
      end
    end
    fsh          = fcnt_n >> shift;
    ext_next_o   = {tmr_n, fsh[FRAC_W-1:0]};
    period_end_o = en_i & tick_last & at_top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      tmr_q  <= '0;
    end else begin
      fcnt_q <= fcnt_n;
      tmr_q  <= tmr_n;
    end
  end

  assign tmr_o = tmr_q;

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(tmr_q) && $stable(fcnt_q)));

  assert_restart_after_top_R3: assert property (@(posedge clk) disable iff (rst)
    period_end_o |=> (tmr_q == '0) && (fcnt_q == '0));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned EXT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic [EXT_W-1:0] dbuf_i,
  input  logic [EXT_W-1:0] ext_next_i,
  output logic             out_o,
  output logic [EXT_W-1:0] shadow_o
);

  logic             out_q;
  logic [EXT_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= 1'b0;
      shadow_q <= '0;
    end else if (!en_i) begin
      out_q <= 1'b0;
    end else if (wrap_i) begin
      shadow_q <= dbuf_i;
      out_q    <= (dbuf_i != '0);
    end else if (ext_next_i == shadow_q) begin
      out_q <= 1'b0;
    end
  end

  assign out_o    = out_q;
  assign shadow_o = shadow_q;

  assert_rise_at_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(wrap_i));

  assert_shadow_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(shadow_q) |-> $past(wrap_i));

  assert_off_drives_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !out_q);

  assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (rst)
    out_q |-> (shadow_q != '0));

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [TMR_W-1:0]        reg_wdata,
  output logic                    pwm_out,
  output logic [TMR_W+FRAC_W-1:0] shadow_duty,
  output logic [TMR_W-1:0]        timer_count
);

  localparam int unsigned EXT_W = TMR_W + FRAC_W;

  logic [EXT_W-1:0] dbuf, ext_next;
  logic [TMR_W-1:0] period;
  logic             en, wrap;
  logic [1:0]       ps_sel;

  pwm_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .dbuf_o(dbuf), .period_o(period), .en_o(en), .ps_sel_o(ps_sel)
  );

  pwm_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) tb_i (
    .clk(clk), .rst(rst), .en_i(en), .ps_sel_i(ps_sel), .period_i(period),
    .tmr_o(timer_count), .period_end_o(wrap), .ext_next_o(ext_next)
  );

  pwm_compare #(.EXT_W(EXT_W)) cmp_i (
    .clk(clk), .rst(rst), .en_i(en), .wrap_i(wrap), .dbuf_i(dbuf),
    .ext_next_i(ext_next), .out_o(pwm_out), .shadow_o(shadow_duty)
  );

endmodule

// File: tb/pwm_dbuf_gen_tb_top.sv
module pwm_dbuf_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       pwm_out;
  logic [9:0] shadow_duty;
  logic [7:0] timer_count;

  int n_chk = 0;
  int n_fail = 0;
  localparam int LIM = 20000;

  always #10 clk = ~clk;

  pwm_dbuf_gen dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pwm_out(pwm_out), .shadow_duty(shadow_duty), .timer_count(timer_count)
  );

  function automatic int pf(input logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 16;
  endfunction

  function automatic int exp_per(input int pr, input logic [1:0] sel);
    return (pr + 1) * 4 * pf(sel);
  endfunction

  function automatic int exp_hi(input int d, input logic [1:0] sel);
    return d * pf(sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R2: program period, duty, then control (enable bit 2, prescale bits 1:0)
  task automatic cfg(input logic [1:0] sel, input int pr, input int d);
    do_reset();
    wr(2'd2, 8'(pr));
    wr(2'd0, 8'(d >> 2));
    wr(2'd1, 8'(d & 3));
    wr(2'd3, {5'b0, 1'b1, sel});
  endtask

  // waits for a rising edge, then measures high time and rise-to-rise period
  task automatic measure(input bit mid, input logic [9:0] nd,
                         output int hi, output int per, output int sh_fall);
    int  n;
    int  cnt;
    bit  prev, s, done_hi;
    hi = -1; per = -1; sh_fall = -1;
    @(negedge clk);
    prev = pwm_out;
    n = 0;
    while (n < LIM) begin
      @(negedge clk);
      s = pwm_out;
      if (!prev && s) break;
      prev = s;
      n++;
    end
    if (n >= LIM) return;
    hi = 1; cnt = 1; prev = 1'b1; done_hi = 1'b0;
    while (cnt < LIM) begin
      @(negedge clk);
      s = pwm_out;
      if (mid && cnt == 2) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = nd[9:2]; end
      if (mid && cnt == 3) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = {6'b0, nd[1:0]}; end
      if (mid && cnt == 4) reg_wr = 1'b0;
      if (!prev && s) begin per = cnt; break; end
      if (s && !done_hi) hi++;
      if (!s && !done_hi) begin done_hi = 1'b1; sh_fall = int'(shadow_duty); end
      prev = s;
      cnt++;
    end
  endtask

  task automatic run_case(input logic [1:0] sel, input int pr, input int d, input string tag);
    int hi, per, shf;
    cfg(sel, pr, d);
    measure(1'b0, '0, hi, per, shf);
    chk(hi == exp_hi(d, sel), {tag, " R4 high time"}, hi, exp_hi(d, sel));
    chk(per == exp_per(pr, sel), {tag, " R3 period"}, per, exp_per(pr, sel));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int hi, per, shf, tsnap;
    bit all_ok;
    void'($urandom(32'd4711));

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 out after reset", int'(pwm_out), 0);
    chk(timer_count == 8'd0, "R1 timer after reset", int'(timer_count), 0);
    chk(shadow_duty == 10'd0, "R1 shadow after reset", int'(shadow_duty), 0);
    repeat (20) @(negedge clk);
    chk(timer_count == 8'd0, "R1 disabled timer idle", int'(timer_count), 0);

    // R1 default period 0xFF and ratio 1: only duty and enable written
    wr(2'd0, 8'd25);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'h04);
    measure(1'b0, '0, hi, per, shf);
    chk(hi == 100, "R1 R4 default high", hi, 100);
    chk(per == 1024, "R1 R3 default period", per, 1024);

    // R2 R3 R4 directed prescale cases
    run_case(2'b01, 9, 13, "ps4");
    run_case(2'b10, 3, 5, "ps16");
    run_case(2'b11, 2, 7, "ps16b");
    // R4 boundary: duty one below full
    run_case(2'b00, 9, 39, "edge");

    // R7 mid-period duty write
    cfg(2'b00, 19, 30);
    measure(1'b1, 10'd50, hi, per, shf);
    chk(hi == 30, "R7 current pulse unchanged", hi, 30);
    chk(shf == 30, "R7 shadow held during period", shf, 30);
    chk(per == 80, "R7 R3 period", per, 80);
    measure(1'b0, '0, hi, per, shf);
    chk(hi == 50, "R7 next pulse uses new duty", hi, 50);
    chk(shadow_duty == 10'd50, "R7 shadow updated", int'(shadow_duty), 50);

    // R6 zero duty
    cfg(2'b00, 9, 0);
    all_ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (pwm_out) all_ok = 1'b0;
    end
    chk(all_ok, "R6 zero duty stays low", int'(!all_ok), 0);

    // R5 duty at full period value
    cfg(2'b00, 9, 40);
    measure(1'b0, '0, hi, per, shf);
    chk(hi >= 0, "R5 output rose", hi, 0);
    all_ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (!pwm_out) all_ok = 1'b0;
    end
    chk(all_ok, "R5 full duty stays high", int'(!all_ok), 0);

    // R8 disable while high (still in R5 setup, output high)
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8 out low after disable", int'(pwm_out), 0);
    tsnap = int'(timer_count);
    all_ok = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (int'(timer_count) != tsnap || pwm_out) all_ok = 1'b0;
    end
    chk(all_ok, "R8 timer held and out low", int'(timer_count), tsnap);

    // R9 R3 R4 random cases
    for (int i = 0; i < 8; i++) begin
      logic [1:0] sel;
      int pr, d;
      sel = 2'($urandom_range(0, 2));
      pr  = int'($urandom_range(2, 30));
      d   = int'($urandom_range(1, 4 * (pr + 1) - 1));
      run_case(sel, pr, d, "rand R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule